// File: doc/BRIEF.md
# Secure Execution Mode Sequencer

This controller owns the processor's execution mode in a host that keeps guest virtual machines private from their own hypervisor. It tracks four modes: initialization, hypervisor, guest-privileged and guest-user. No mode boundary is crossed without a fixed scrub sequence. Each step of a sequence goes to an external unit as a one-cycle strobe. The units are the cache and RAM, the register file, the image loader, the memory-management unit, the I/O devices and the context save/restore engine. The controller waits for that unit's done pulse before it starts the next step. The controller does not do the scrubbing itself.

A hard reset and a soft reset issued from the hypervisor both wipe memory and every piece of state, then land in initialization. Initialization is left only once, through a leave instruction that turns on the memory-management unit and the loader. Guest entry names a target partition and is refused when that partition is not ready. Guest exit is caused by the watchdog timer interrupt or by a yield. It saves the guest context, scrubs, and returns to the hypervisor partition at a vectored program counter.

Top module: `modeseq_top`

## Requirements
- R1: After `rst` falls, `mode` is 0 (initialization; the mode codes are 0 initialization, 1 hypervisor, 2 guest-privileged, 3 guest-user), `mmu_en` and `loader_en` are 0 and `busy` is 1. The steps wipe (bit 0), register reset (bit 2), loader reset (bit 3), MMU off (bit 4) and I/O reset (bit 7) then run in that order. The sequence ends with a `pc_load` pulse that has `pc_sel`=0 (reset vector). Mode 0 is followed only by mode 0 or mode 1.
- R2: Each step raises one bit of `step_req` for exactly one cycle. The op-to-unit map is: ops 0 and 1 go to unit 0 (cache/RAM), op 2 to unit 1 (registers), op 3 to unit 2 (loader), ops 4, 5 and 6 to unit 3 (MMU), op 7 to unit 4 (I/O), and ops 8 and 9 to unit 5 (context). The next step starts the cycle after the mapped `unit_done` bit is seen high in a cycle after its strobe. Done bits of other units are ignored.
- R3: `leave_init_req` in mode 0 runs flush (bit 1), register reset and MMU on (bit 5). It then enters mode 1 with `mmu_en` and `loader_en` set and a `pc_load` with `pc_sel`=1. `loader_en` is never 1 in mode 0.
- R4: A leave request outside mode 0, an enter request outside mode 1, or a yield in mode 0 or 1 raises `illegal_fault` for one cycle and starts no sequence.
- R5: `enter_req` in mode 1 with `part_loaded` high runs flush, register reset and MMU switch (bit 6). On that switch `act_part` takes the `enter_part` value latched at the request, and the mode becomes 2. A context restore (bit 9) follows. When it completes, the mode becomes 2 if `ctx_priv` is 1 and 3 if it is 0, with a `pc_load` and `pc_sel`=3. Mode 3 is never entered straight from mode 1.
- R6: `enter_req` in mode 1 with `part_loaded` low raises `entry_fault` for one cycle. The mode stays 1 and `act_part` stays 0.
- R7: `nmi_timer` or `yield_req` in mode 2 or 3 runs context save (bit 8), flush, register reset and MMU switch with `act_part` going to 0. It ends in mode 1 with a `pc_load` and `pc_sel`=2. `nmi_timer` in mode 0 or 1 has no effect.
- R8: `soft_rst_req` in mode 0 or 1 runs the full R1 sequence. In mode 2 it runs flush and register reset, then stays in mode 2 with a `pc_load` and `pc_sel`=4. In mode 3 it raises `illegal_fault`.
- R9: While `busy` is 1, every request is ignored and no fault is raised.
- R10: When requests arrive together, the order is soft reset, then timer interrupt (only when in a guest mode), then yield, then enter, then leave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst_req | input | 1 | Soft reset instruction |
| leave_init_req | input | 1 | Leave-initialization instruction |
| enter_req | input | 1 | Guest entry request |
| enter_part | input | PART_W | Target partition of guest entry |
| part_loaded | input | 1 | Target partition holds a loaded image |
| yield_req | input | 1 | Guest yield instruction |
| nmi_timer | input | 1 | Non-maskable timer interrupt |
| ctx_priv | input | 1 | Privilege bit of the restored guest context |
| unit_done | input | 6 | Per-unit step completion pulses |
| step_req | output | 10 | One-hot step strobe, one bit per operation |
| mode | output | 2 | Current execution mode |
| mmu_en | output | 1 | Memory-management unit enabled |
| loader_en | output | 1 | Image loader enabled |
| act_part | output | PART_W | Active memory partition (0 is the hypervisor) |
| pc_load | output | 1 | Program counter load pulse |
| pc_sel | output | 3 | Program counter source for the load |
| illegal_fault | output | 1 | Illegal instruction fault pulse |
| entry_fault | output | 1 | Guest entry refused pulse |
| busy | output | 1 | A sequence is in progress |

## Verification
The assertions take for granted that each unit answers a strobe with a done pulse of its own. They also assume that done bits of other units may show up at any time without meaning anything. The stimulus gives every request as a one-cycle pulse while the clock is low. The done responder answers only after a strobe, with a latency of one to three cycles. Some phases add deliberate noise on the other units' done lines to exercise the rule that only the pending unit's done bit advances a sequence.

// File: rtl/modeseq_pkg.sv
package modeseq_pkg;

    typedef enum logic [1:0] {
        MD_INIT  = 2'd0,
        MD_HYP   = 2'd1,
        MD_VPRIV = 2'd2,
        MD_VPROT = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        OP_WIPE    = 4'd0,
        OP_FLUSH   = 4'd1,
        OP_REGRST  = 4'd2,
        OP_LDRRST  = 4'd3,
        OP_MMUOFF  = 4'd4,
        OP_MMUON   = 4'd5,
        OP_MMUSW   = 4'd6,
        OP_IORST   = 4'd7,
        OP_CTXSAVE = 4'd8,
        OP_CTXLOAD = 4'd9
    } op_e;

    typedef enum logic [2:0] {
        SQ_RESET,
        SQ_LEAVE,
        SQ_ENTER,
        SQ_EXIT,
        SQ_VMRST
    } seq_e;

    typedef enum logic [2:0] {
        PC_RESET  = 3'd0,
        PC_HYPFIX = 3'd1,
        PC_HYPVEC = 3'd2,
        PC_CTX    = 3'd3,
        PC_VMRST  = 3'd4
    } pc_e;

    localparam int NOP     = 10;
    localparam int NUNIT   = 6;
    localparam int MAX_LEN = 5;
    localparam int IDX_W   = $clog2(MAX_LEN);

    function automatic op_e seq_op(seq_e s, logic [IDX_W-1:0] i);
        op_e o;
        o = OP_FLUSH;
        case (s)
            SQ_RESET: case (i)
                3'd0: o = OP_WIPE;
                3'd1: o = OP_REGRST;
                3'd2: o = OP_LDRRST;
                3'd3: o = OP_MMUOFF;
                default: o = OP_IORST;
            endcase
            SQ_LEAVE: case (i)
                3'd0: o = OP_FLUSH;
                3'd1: o = OP_REGRST;
                default: o = OP_MMUON;
            endcase
            SQ_ENTER: case (i)
                3'd0: o = OP_FLUSH;
                3'd1: o = OP_REGRST;
                3'd2: o = OP_MMUSW;
                default: o = OP_CTXLOAD;
            endcase
            SQ_EXIT: case (i)
                3'd0: o = OP_CTXSAVE;
                3'd1: o = OP_FLUSH;
                3'd2: o = OP_REGRST;
                default: o = OP_MMUSW;
            endcase
            default: case (i)
                3'd0: o = OP_FLUSH;
                default: o = OP_REGRST;
            endcase
        endcase
        return o;
    endfunction

    function automatic logic [IDX_W-1:0] seq_len(seq_e s);
        case (s)
            SQ_RESET: return IDX_W'(5);
            SQ_LEAVE: return IDX_W'(3);
            SQ_ENTER: return IDX_W'(4);
            SQ_EXIT:  return IDX_W'(4);
            default:  return IDX_W'(2);
        endcase
    endfunction

    function automatic logic [2:0] op_unit(op_e o);
        case (o)
            OP_WIPE, OP_FLUSH:            return 3'd0;
            OP_REGRST:                    return 3'd1;
            OP_LDRRST:                    return 3'd2;
            OP_MMUOFF, OP_MMUON, OP_MMUSW: return 3'd3;
            OP_IORST:                     return 3'd4;
            default:                      return 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/modeseq_arbiter.sv
module modeseq_arbiter
    import modeseq_pkg::*;
(
    input  mode_e mode,
    input  logic  soft_rst_req,
    input  logic  nmi_timer,
    input  logic  yield_req,
    input  logic  enter_req,
    input  logic  leave_init_req,
    input  logic  part_loaded,
    output logic  go,
    output seq_e  go_seq,
    output logic  bad_instr,
    output logic  bad_entry
);
    logic in_guest;
    assign in_guest = (mode == MD_VPRIV) || (mode == MD_VPROT);

    always_comb begin
        go        = 1'b0;
        go_seq    = SQ_RESET;
        bad_instr = 1'b0;
        bad_entry = 1'b0;
        if (soft_rst_req) begin
            case (mode)
                MD_VPROT: bad_instr = 1'b1;
                MD_VPRIV: begin go = 1'b1; go_seq = SQ_VMRST; end
                default:  begin go = 1'b1; go_seq = SQ_RESET; end
            endcase
        end else if (nmi_timer && in_guest) begin
            go = 1'b1;
            go_seq = SQ_EXIT;
        end else if (yield_req) begin
            if (in_guest) begin go = 1'b1; go_seq = SQ_EXIT; end
            else bad_instr = 1'b1;
        end else if (enter_req) begin
            if (mode != MD_HYP) bad_instr = 1'b1;
            else if (!part_loaded) bad_entry = 1'b1;
            else begin go = 1'b1; go_seq = SQ_ENTER; end
        end else if (leave_init_req) begin
            if (mode == MD_INIT) begin go = 1'b1; go_seq = SQ_LEAVE; end
            else bad_instr = 1'b1;
        end
    end
endmodule

// File: rtl/modeseq_stepper.sv
module modeseq_stepper
    import modeseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  seq_e             start_seq,
    input  logic [NUNIT-1:0] unit_done,
    output logic             busy,
    output seq_e             cur_seq,
    output op_e              cur_op,
    output logic             issue,
    output logic             step_fire,
    output logic             last_step
);
    typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT} phase_e;

    phase_e           ph;
    logic [IDX_W-1:0] idx;

    assign cur_op    = seq_op(cur_seq, idx);
    assign issue     = (ph == PH_ISSUE);
    assign busy      = (ph != PH_IDLE);
    assign step_fire = (ph == PH_WAIT) && unit_done[op_unit(cur_op)];
    assign last_step = (idx == seq_len(cur_seq) - IDX_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_ISSUE;
            cur_seq <= SQ_RESET;
            idx     <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    ph      <= PH_ISSUE;
                    cur_seq <= start_seq;
                    idx     <= '0;
                end
                PH_ISSUE: ph <= PH_WAIT;
                default: if (step_fire) begin
                    if (last_step) ph <= PH_IDLE;
                    else begin
                        idx <= idx + IDX_W'(1);
                        ph  <= PH_ISSUE;
                    end
                end
            endcase
        end
    end

    // R2
    step_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        issue |=> !issue);

    // R2
    idle_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (step_fire && last_step) |=> !busy);
endmodule

// File: rtl/modeseq_top.sv
module modeseq_top
    import modeseq_pkg::*;
#(
    parameter int PART_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst_req,
    input  logic              leave_init_req,
    input  logic              enter_req,
    input  logic [PART_W-1:0] enter_part,
    input  logic              part_loaded,
    input  logic              yield_req,
    input  logic              nmi_timer,
    input  logic              ctx_priv,
    input  logic [5:0]        unit_done,
    output logic [9:0]        step_req,
    output logic [1:0]        mode,
    output logic              mmu_en,
    output logic              loader_en,
    output logic [PART_W-1:0] act_part,
    output logic              pc_load,
    output logic [2:0]        pc_sel,
    output logic              illegal_fault,
    output logic              entry_fault,
    output logic              busy
);
    mode_e             mode_q;
    pc_e               pc_q;
    logic [PART_W-1:0] tgt_part;
    logic              go, bad_instr, bad_entry, start;
    seq_e              go_seq, cur_seq;
    op_e               cur_op;
    logic              issue, step_fire, last_step;

    modeseq_arbiter u_arb (
        .mode           (mode_q),
        .soft_rst_req   (soft_rst_req),
        .nmi_timer      (nmi_timer),
        .yield_req      (yield_req),
        .enter_req      (enter_req),
        .leave_init_req (leave_init_req),
        .part_loaded    (part_loaded),
        .go             (go),
        .go_seq         (go_seq),
        .bad_instr      (bad_instr),
        .bad_entry      (bad_entry)
    );

    assign start = go && !busy;

    modeseq_stepper u_step (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_seq (go_seq),
        .unit_done (unit_done[NUNIT-1:0]),
        .busy      (busy),
        .cur_seq   (cur_seq),
        .cur_op    (cur_op),
        .issue     (issue),
        .step_fire (step_fire),
        .last_step (last_step)
    );

    assign step_req = issue ? (NOP'(1) << cur_op) : '0;
    assign mode     = mode_q;
    assign pc_sel   = pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q        <= MD_INIT;
            mmu_en        <= 1'b0;
            loader_en     <= 1'b0;
            act_part      <= '0;
            tgt_part      <= '0;
            pc_load       <= 1'b0;
            pc_q          <= PC_RESET;
            illegal_fault <= 1'b0;
            entry_fault   <= 1'b0;
        end else begin
            pc_load       <= 1'b0;
            illegal_fault <= !busy && bad_instr;
            entry_fault   <= !busy && bad_entry;
            if (start && go_seq == SQ_ENTER) tgt_part <= enter_part;
            if (step_fire) begin
                case (cur_op)
                    OP_MMUOFF: begin mmu_en <= 1'b0; act_part <= '0; end
                    OP_MMUON:  begin mmu_en <= 1'b1; act_part <= '0; end
                    OP_MMUSW: begin
                        if (cur_seq == SQ_ENTER) begin
                            act_part <= tgt_part;
                            mode_q   <= MD_VPRIV;
                        end else begin
                            act_part <= '0;
                        end
                    end
                    OP_LDRRST: loader_en <= 1'b0;
                    OP_CTXLOAD: begin
                        mode_q  <= ctx_priv ? MD_VPRIV : MD_VPROT;
                        pc_load <= 1'b1;
                        pc_q    <= PC_CTX;
                    end
                    default: ;
                endcase
                if (last_step) begin
                    case (cur_seq)
                        SQ_RESET: begin
                            mode_q <= MD_INIT; pc_load <= 1'b1; pc_q <= PC_RESET;
                        end
                        SQ_LEAVE: begin
                            mode_q <= MD_HYP; loader_en <= 1'b1;
                            pc_load <= 1'b1; pc_q <= PC_HYPFIX;
                        end
                        SQ_EXIT: begin
                            mode_q <= MD_HYP; pc_load <= 1'b1; pc_q <= PC_HYPVEC;
                        end
                        SQ_VMRST: begin
                            mode_q <= MD_VPRIV; pc_load <= 1'b1; pc_q <= PC_VMRST;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R2
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_req));

    // R3
    no_loader_in_init_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_INIT) |-> !loader_en);

    // R1
    init_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_INIT) |=> (mode_q == MD_INIT || mode_q == MD_HYP));

    // R5
    no_direct_user_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MD_HYP) |=> (mode_q != MD_VPROT));

    // R6
    refused_entry_chk: assert property (@(posedge clk) disable iff (rst)
        entry_fault |-> (mode_q == MD_HYP && act_part == '0));

    // R9
    quiet_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !(illegal_fault || entry_fault));
endmodule

// File: tb/tb_modeseq_top.sv
module tb_modeseq_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst_req = 0, leave_init_req = 0, enter_req = 0;
    logic [2:0] enter_part = 0;
    logic       part_loaded = 0, yield_req = 0, nmi_timer = 0, ctx_priv = 0;
    logic [5:0] unit_done = 0;
    logic [9:0] step_req;
    logic [1:0] mode;
    logic       mmu_en, loader_en, pc_load, illegal_fault, entry_fault, busy;
    logic [2:0] act_part, pc_sel;

    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    modeseq_top #(.PART_W(3)) dut (
        .clk(clk), .rst(rst), .soft_rst_req(soft_rst_req),
        .leave_init_req(leave_init_req), .enter_req(enter_req),
        .enter_part(enter_part), .part_loaded(part_loaded),
        .yield_req(yield_req), .nmi_timer(nmi_timer), .ctx_priv(ctx_priv),
        .unit_done(unit_done), .step_req(step_req), .mode(mode),
        .mmu_en(mmu_en), .loader_en(loader_en), .act_part(act_part),
        .pc_load(pc_load), .pc_sel(pc_sel), .illegal_fault(illegal_fault),
        .entry_fault(entry_fault), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int unit_of(input int op);
        case (op)
            0, 1:    return 0;
            2:       return 1;
            3:       return 2;
            4, 5, 6: return 3;
            7:       return 4;
            default: return 5;
        endcase
    endfunction

    // ---------------- done responder ----------------
    int lat = 1;
    bit noisy = 0;
    int cnt = 0;
    int pend = 0;
    always @(negedge clk) begin
        unit_done = '0;
        if (cnt > 0) begin
            cnt--;
            if (cnt == 0) unit_done[pend] = 1'b1;
            else if (noisy) unit_done = ~(6'b1 << pend);
        end
        if (step_req != 0) begin
            for (int b = 0; b < 10; b++)
                if (step_req[b]) pend = unit_of(b);
            cnt = lat;
        end
    end

    // ---------------- reference model ----------------
    int q[$];
    bit m_busy, m_issue, e_pcload, e_ill, e_ent, m_mmu, m_ldr;
    int m_kind, m_mode, m_part, m_tgt, e_pcsel;

    task automatic begin_seq(input int k);
        case (k)
            0: q = '{0, 2, 3, 4, 7};
            1: q = '{1, 2, 5};
            2: q = '{1, 2, 6, 9};
            3: q = '{8, 1, 2, 6};
            default: q = '{1, 2};
        endcase
        m_kind = k; m_busy = 1; m_issue = 1;
    endtask

    always @(posedge clk) begin
        int op;
        bit vm;
        e_pcload = 0; e_ill = 0; e_ent = 0;
        if (rst) begin
            m_mode = 0; m_mmu = 0; m_ldr = 0; m_part = 0; m_tgt = 0; e_pcsel = 0;
            begin_seq(0);
        end else if (m_busy) begin
            if (m_issue) m_issue = 0;
            else if (unit_done[unit_of(q[0])]) begin
                op = q.pop_front();
                if (op == 4) begin m_mmu = 0; m_part = 0; end
                if (op == 5) begin m_mmu = 1; m_part = 0; end
                if (op == 6) begin
                    m_part = (m_kind == 2) ? m_tgt : 0;
                    if (m_kind == 2) m_mode = 2;
                end
                if (op == 3) m_ldr = 0;
                if (op == 9) begin m_mode = ctx_priv ? 2 : 3; e_pcload = 1; e_pcsel = 3; end
                if (q.size() == 0) begin
                    m_busy = 0;
                    case (m_kind)
                        0: begin m_mode = 0; e_pcload = 1; e_pcsel = 0; end
                        1: begin m_mode = 1; m_ldr = 1; e_pcload = 1; e_pcsel = 1; end
                        3: begin m_mode = 1; e_pcload = 1; e_pcsel = 2; end
                        4: begin m_mode = 2; e_pcload = 1; e_pcsel = 4; end
                        default: ;
                    endcase
                end else m_issue = 1;
            end
        end else begin
            vm = (m_mode >= 2);
            if (soft_rst_req) begin
                if (m_mode == 3) e_ill = 1;
                else if (m_mode == 2) begin_seq(4);
                else begin_seq(0);
            end else if (nmi_timer && vm) begin_seq(3);
            else if (yield_req) begin
                if (vm) begin_seq(3); else e_ill = 1;
            end else if (enter_req) begin
                if (m_mode != 1) e_ill = 1;
                else if (!part_loaded) e_ent = 1;
                else begin m_tgt = enter_part; begin_seq(2); end
            end else if (leave_init_req) begin
                if (m_mode == 0) begin_seq(1); else e_ill = 1;
            end
        end
    end

    // compare every cycle, 1 ns after the edge
    always @(posedge clk) begin
        int er;
        #1;
        if (!rst) begin
            er = (m_busy && m_issue) ? (1 << q[0]) : 0;
            chk(step_req == 10'(er), "R2 step_req", step_req, er);
            chk(mode == 2'(m_mode), "R1 mode", mode, m_mode);
            chk(mmu_en == m_mmu && act_part == 3'(m_part), "R5 mmu_en/act_part",
                {mmu_en, act_part}, {m_mmu, 3'(m_part)});
            chk(loader_en == m_ldr, "R3 loader_en", loader_en, m_ldr);
            chk(pc_load == e_pcload && pc_sel == 3'(e_pcsel), "R7 pc_load/pc_sel",
                {pc_load, pc_sel}, {e_pcload, 3'(e_pcsel)});
            chk(illegal_fault == e_ill, "R4 illegal_fault", illegal_fault, e_ill);
            chk(entry_fault == e_ent, "R6 entry_fault", entry_fault, e_ent);
            chk(busy == m_busy, "R9 busy", busy, m_busy);
        end
    end

    // ---------------- stimulus ----------------
    task automatic pulse(input bit s, input bit n, input bit y, input bit e, input bit l);
        @(negedge clk);
        soft_rst_req = s; nmi_timer = n; yield_req = y; enter_req = e; leave_init_req = l;
        @(negedge clk);
        soft_rst_req = 0; nmi_timer = 0; yield_req = 0; enter_req = 0; leave_init_req = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(busy == 1 && mode == 0 && loader_en == 0, "R1 reset state", {busy, mode}, 4);
        wait_idle();
        chk(mode == 0 && !busy, "R1 idle in init", mode, 0);

        pulse(0, 1, 0, 0, 0);                 // R7 timer in init ignored
        repeat (2) @(negedge clk);
        chk(mode == 0 && !busy, "R7 nmi ignored in init", mode, 0);
        pulse(0, 0, 0, 1, 0);                 // R4 enter in init
        pulse(0, 0, 1, 0, 0);                 // R4 yield in init
        wait_idle();

        lat = 2;
        pulse(0, 0, 0, 0, 1);                 // R3 leave init
        wait_idle();
        chk(mode == 1 && mmu_en && loader_en, "R3 in hypervisor", mode, 1);
        pulse(0, 0, 0, 0, 1);                 // R4 leave again
        wait_idle();

        enter_part = 3'd5; part_loaded = 0;
        pulse(0, 0, 0, 1, 0);                 // R6 refused
        wait_idle();
        chk(mode == 1 && act_part == 0, "R6 stays hypervisor", mode, 1);

        lat = 3; noisy = 1; part_loaded = 1; ctx_priv = 0;
        pulse(0, 0, 0, 1, 0);                 // R5 enter, user context
        wait_idle();
        chk(mode == 3 && act_part == 5, "R5 guest user", {mode, act_part}, {2'd3, 3'd5});
        pulse(1, 0, 0, 0, 0);                 // R8 soft reset illegal in user
        wait_idle();
        chk(mode == 3, "R8 user soft reset refused", mode, 3);
        pulse(0, 1, 0, 0, 0);                 // R7 timer exit
        wait_idle();
        chk(mode == 1 && act_part == 0, "R7 back to hypervisor", {mode, act_part}, 8);

        noisy = 0; lat = 1; enter_part = 3'd2; ctx_priv = 1;
        pulse(0, 0, 0, 1, 0);                 // R5 enter, privileged context
        pulse(0, 0, 1, 0, 1);                 // R9 ignored while busy
        wait_idle();
        chk(mode == 2 && act_part == 2, "R9 busy requests ignored", {mode, act_part}, {2'd2, 3'd2});

        pulse(1, 1, 0, 0, 0);                 // R10 soft beats timer
        wait_idle();
        chk(mode == 2 && act_part == 2, "R10 R8 guest restart", {mode, act_part}, {2'd2, 3'd2});
        pulse(0, 0, 1, 0, 0);                 // R7 yield exit
        wait_idle();
        chk(mode == 1, "R7 yield exit", mode, 1);

        enter_part = 3'd7;
        pulse(0, 0, 0, 1, 1);                 // R10 enter beats leave
        wait_idle();
        chk(mode == 2 && act_part == 7, "R10 enter priority", {mode, act_part}, {2'd2, 3'd7});
        pulse(0, 0, 1, 0, 0);
        wait_idle();

        lat = 2;
        pulse(1, 0, 0, 0, 0);                 // R8 soft reset from hypervisor
        wait_idle();
        chk(mode == 0 && !loader_en && !mmu_en, "R8 full reset", mode, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule